// File: doc/BRIEF.md
# Secure-Aware Interrupt Acknowledge and Completion Unit

This block is the acknowledge and completion logic of one processor's port on an interrupt controller whose interrupts fall into a secure group (group 0) and a non-secure group (group 1). Arbitration happens upstream and hands the block the winning pending interrupt: its ID, priority and group. When the processor reads the acknowledge register, the block returns that ID, or one of two reserved IDs. The choice depends on the security attribute of the read, on an acknowledge-control bit and on the current running priority. If the acknowledge is granted, the interrupt becomes the running one.

When the processor writes an end-of-interrupt ID, the block restores the running state that was in force before the matching acknowledge. Each grant saves the interrupted running state on a small nesting stack. Completions made by a non-secure requester for secure interrupts are dropped without effect. A parameter removes the security extension, and every request is then handled as secure.

Top module: `sec_ack_unit`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100 (idle), and no acknowledge or completion is signalled.
- R2: If the pending ID is at or above NUM_IRQ (1020 by default, so 1020 to 1023), an acknowledge returns that ID unchanged and nothing is granted.
- R3: If the pending interrupt is in group 0 (pend_grp=0) and the request is non-secure (req_secure=0), an acknowledge returns 1023 and changes no state.
- R4: If the pending interrupt is in group 1 (pend_grp=1) and the request is secure, an acknowledge returns 1022 when ack_ctl=0. When ack_ctl=1, the acknowledge proceeds normally.
- R5: A non-secure acknowledge of a group 1 interrupt whose priority is strictly below the running priority returns its ID and is granted.
- R6: If the pending priority is not strictly below the running priority (equal included), an acknowledge returns 1023 and changes nothing.
- R7: A granted acknowledge raises ack_taken in the same cycle. On the next edge run_id takes pend_id and run_prio takes pend_prio, zero-extended. If an interrupt was running, its ID and priority are saved first.
- R8: A permitted completion whose eoi_id equals run_id restores the most recently saved running state. If nothing is saved, it restores 1023 / 0x100. eoi_done is high in that cycle.
- R9: A completion whose eoi_id differs from run_id, or is at or above NUM_IRQ, changes nothing.
- R10: A non-secure completion with eoi_grp=0 is ignored. A secure completion of a group 1 interrupt is carried out even when ack_ctl=0.
- R11: If 4 states are already saved (DEPTH) and an interrupt is running, an acknowledge returns 1023 and changes nothing.
- R12: When ack_req and eoi_req are both high in one cycle, the acknowledge is processed and the completion has no effect.
- R13: With HAS_SEC=0 every request is handled as secure. A group 0 interrupt is then acknowledged for a non-secure requester, and that requester's completion of group 0 takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge read strobe |
| pend_id | input | 10 | ID of the highest pending interrupt (1023 = none) |
| pend_prio | input | PRIO_W | Priority of the pending interrupt (lower value = more urgent) |
| pend_grp | input | 1 | Group of the pending interrupt (0 secure, 1 non-secure) |
| req_secure | input | 1 | Security attribute of the current access |
| ack_ctl | input | 1 | Acknowledge-control bit: secure reads may take group 1 |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | Interrupt ID named by the completion write |
| eoi_grp | input | 1 | Group of the interrupt named by the completion |
| ack_id | output | 10 | Returned ID; valid while ack_req is high, 1023 otherwise |
| ack_taken | output | 1 | The acknowledge in this cycle is granted |
| eoi_done | output | 1 | The completion in this cycle takes effect |
| run_id | output | 10 | ID of the running interrupt (1023 = idle) |
| run_prio | output | PRIO_W+1 | Running priority (0x100 = idle) |

## Verification
The bench targets the places where the two reserved IDs get mixed up. A design that swaps them returns 1022 to a non-secure requester, or 1023 to a secure requester that lacks acknowledge control. The bench also drives an equal-priority acknowledge: a design that compares with less-or-equal would preempt itself and overwrite the running state. Nested grants fill the stack to overflow, and completions then unwind it one level at a time, so a design with off-by-one depth or pop order restores the wrong ID. Non-secure completions of secure interrupts, and cycles that carry both strobes, catch a design that lets a blocked or dropped completion pop the stack.

// File: rtl/sec_ack_pkg.sv
package sec_ack_pkg;

  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] ID_NONE   = 10'd1023;
  localparam logic [ID_W-1:0] ID_HIDDEN = 10'd1022;

  typedef enum logic [1:0] {
    VIS_OPEN    = 2'd0,
    VIS_PASS    = 2'd1,
    VIS_HIDE_NS = 2'd2,
    VIS_HIDE_S  = 2'd3
  } vis_e;

  // Effective security of a request.
  function automatic logic eff_secure(input logic has_sec, input logic req_sec);
    return !has_sec || req_sec;
  endfunction

  // Visibility of the pending interrupt to a requester.
  function automatic vis_e classify(input logic [ID_W-1:0] id,
                                    input logic grp1,
                                    input logic sec,
                                    input logic ackctl,
                                    input int unsigned num_irq);
    vis_e v;
    if (32'(id) >= num_irq)          v = VIS_PASS;
    else if (!grp1 && !sec)          v = VIS_HIDE_NS;
    else if (grp1 && sec && !ackctl) v = VIS_HIDE_S;
    else                             v = VIS_OPEN;
    return v;
  endfunction

  // Strict priority test: pending must be more urgent than running.
  function automatic logic prio_beats(input logic [15:0] pend, input logic [15:0] run);
    return pend < run;
  endfunction

endpackage

// File: rtl/sec_ack_filter.sv
module sec_ack_filter
  import sec_ack_pkg::*;
#(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned NUM_IRQ = 1020,
  parameter bit          HAS_SEC = 1'b1,
  localparam int unsigned RP_W   = PRIO_W + 1
) (
  input  logic              ack_req,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_grp,
  input  logic              req_secure,
  input  logic              ack_ctl,
  input  logic [RP_W-1:0]   run_prio,
  input  logic              stack_full,
  output logic [ID_W-1:0]   ack_id,
  output logic              grant
);

  logic            sec_eff;
  logic            prio_ok;
  vis_e            vis;
  logic [ID_W-1:0] resp;

  always_comb begin
    sec_eff = eff_secure(HAS_SEC, req_secure);
    vis     = classify(pend_id, pend_grp, sec_eff, ack_ctl, NUM_IRQ);
    prio_ok = prio_beats(16'(pend_prio), 16'(run_prio));
    resp    = ID_NONE;
    grant   = 1'b0;
    unique case (vis)
      VIS_PASS:    resp = pend_id;
      VIS_HIDE_NS: resp = ID_NONE;
      VIS_HIDE_S:  resp = ID_HIDDEN;
      default: begin
        if (prio_ok && !stack_full) begin
          resp  = pend_id;
          grant = ack_req;
        end
      end
    endcase
    ack_id = ack_req ? resp : ID_NONE;
  end

endmodule

// File: rtl/sec_ack_eoi.sv
module sec_ack_eoi
  import sec_ack_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 1020,
  parameter bit          HAS_SEC = 1'b1
) (
  input  logic            eoi_req,
  input  logic            ack_req,
  input  logic [ID_W-1:0] eoi_id,
  input  logic            eoi_grp,
  input  logic            req_secure,
  input  logic [ID_W-1:0] run_id,
  output logic            pop
);

  logic sec_eff;
  logic blocked;
  logic in_range;
  logic hit;

  always_comb begin
    sec_eff  = eff_secure(HAS_SEC, req_secure);
    blocked  = !sec_eff && !eoi_grp;
    in_range = 32'(eoi_id) < NUM_IRQ;
    hit      = in_range && (eoi_id == run_id);
    pop      = eoi_req && !ack_req && !blocked && hit;
  end

endmodule

// File: rtl/sec_ack_stack.sv
module sec_ack_stack
  import sec_ack_pkg::*;
#(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned RP_W  = PRIO_W + 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ID_W-1:0]   new_id,
  input  logic [PRIO_W-1:0] new_prio,
  output logic [ID_W-1:0]   cur_id,
  output logic [RP_W-1:0]   cur_prio,
  output logic              full
);

  localparam logic [RP_W-1:0] IDLE_RP = RP_W'(1) << PRIO_W;

  logic [ID_W-1:0]  sv_id   [DEPTH];
  logic [RP_W-1:0]  sv_prio [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             save;
  logic [ID_W-1:0]  top_id;
  logic [RP_W-1:0]  top_prio;

  assign save = push && (cur_id != ID_NONE);
  assign full = (cnt == CNT_W'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ID_W-1:0] id_q;
    logic [RP_W-1:0] prio_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q   <= ID_NONE;
        prio_q <= IDLE_RP;
      end else if (save && (cnt == CNT_W'(i))) begin
        id_q   <= cur_id;
        prio_q <= cur_prio;
      end
    end
    assign sv_id[i]   = id_q;
    assign sv_prio[i] = prio_q;
  end

  always_comb begin
    top_id   = ID_NONE;
    top_prio = IDLE_RP;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CNT_W'(i + 1)) begin
        top_id   = sv_id[i];
        top_prio = sv_prio[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_id   <= ID_NONE;
      cur_prio <= IDLE_RP;
      cnt      <= '0;
    end else if (push) begin
      cur_id   <= new_id;
      cur_prio <= {1'b0, new_prio};
      if (save) cnt <= cnt + CNT_W'(1);
    end else if (pop) begin
      cur_id   <= top_id;
      cur_prio <= top_prio;
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/sec_ack_unit.sv
module sec_ack_unit
  import sec_ack_pkg::*;
#(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned NUM_IRQ = 1020,
  parameter int unsigned DEPTH   = 4,
  parameter bit          HAS_SEC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_req,
  input  logic [9:0]        pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_grp,
  input  logic              req_secure,
  input  logic              ack_ctl,
  input  logic              eoi_req,
  input  logic [9:0]        eoi_id,
  input  logic              eoi_grp,
  output logic [9:0]        ack_id,
  output logic              ack_taken,
  output logic              eoi_done,
  output logic [9:0]        run_id,
  output logic [PRIO_W:0]   run_prio
);

  logic stack_full;

  sec_ack_filter #(.PRIO_W(PRIO_W), .NUM_IRQ(NUM_IRQ), .HAS_SEC(HAS_SEC)) u_filter (
    .ack_req    (ack_req),
    .pend_id    (pend_id),
    .pend_prio  (pend_prio),
    .pend_grp   (pend_grp),
    .req_secure (req_secure),
    .ack_ctl    (ack_ctl),
    .run_prio   (run_prio),
    .stack_full (stack_full),
    .ack_id     (ack_id),
    .grant      (ack_taken)
  );

  sec_ack_eoi #(.NUM_IRQ(NUM_IRQ), .HAS_SEC(HAS_SEC)) u_eoi (
    .eoi_req    (eoi_req),
    .ack_req    (ack_req),
    .eoi_id     (eoi_id),
    .eoi_grp    (eoi_grp),
    .req_secure (req_secure),
    .run_id     (run_id),
    .pop        (eoi_done)
  );

  sec_ack_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_taken),
    .pop      (eoi_done),
    .new_id   (pend_id),
    .new_prio (pend_prio),
    .cur_id   (run_id),
    .cur_prio (run_prio),
    .full     (stack_full)
  );

endmodule

// File: rtl/sec_ack_unit_chk.sv
module sec_ack_unit_chk #(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned NUM_IRQ = 1020,
  parameter bit          HAS_SEC = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_req,
  input logic [9:0]        pend_id,
  input logic [PRIO_W-1:0] pend_prio,
  input logic              req_secure,
  input logic              eoi_req,
  input logic              eoi_grp,
  input logic [9:0]        ack_id,
  input logic              ack_taken,
  input logic              eoi_done,
  input logic [9:0]        run_id,
  input logic [PRIO_W:0]   run_prio,
  input logic              stack_full
);

  localparam logic [PRIO_W:0] IDLE_RP = (PRIO_W+1)'(1) << PRIO_W;

  // R2, R3, R4: a refused acknowledge always returns an ID outside the valid range
  p_refused_special_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !ack_taken |-> 32'(ack_id) >= NUM_IRQ);

  // R6: a grant only happens for a strictly more urgent interrupt
  p_grant_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken |-> {1'b0, pend_prio} < run_prio);

  // R6: a refused acknowledge leaves the running state alone
  p_refused_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && !ack_taken |=> $stable(run_id) && $stable(run_prio));

  // R7: a grant loads the pending interrupt as running
  p_grant_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken |=> run_id == $past(pend_id) && run_prio == {1'b0, $past(pend_prio)});

  // R8: idle ID and idle priority go together
  p_idle_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_id == 10'd1023 |-> run_prio == IDLE_RP);

  // R10: non-secure completion of a secure interrupt has no effect
  p_ns_eoi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    HAS_SEC && eoi_req && !req_secure && !eoi_grp |-> !eoi_done);

  // R11: no grant while the nesting stack is full
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full && ack_req |-> !ack_taken);

  // R12: a completion that shares its cycle with an acknowledge is dropped
  p_ack_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req && eoi_req |-> !eoi_done);

endmodule

bind sec_ack_unit sec_ack_unit_chk #(.PRIO_W(PRIO_W), .NUM_IRQ(NUM_IRQ), .HAS_SEC(HAS_SEC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_req    (ack_req),
  .pend_id    (pend_id),
  .pend_prio  (pend_prio),
  .req_secure (req_secure),
  .eoi_req    (eoi_req),
  .eoi_grp    (eoi_grp),
  .ack_id     (ack_id),
  .ack_taken  (ack_taken),
  .eoi_done   (eoi_done),
  .run_id     (run_id),
  .run_prio   (run_prio),
  .stack_full (stack_full)
);

// File: tb/sec_ack_unit_bench.sv
module sec_ack_unit_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       ack_req = 0, pend_grp = 0, req_secure = 0, ack_ctl = 0;
  logic       eoi_req = 0, eoi_grp = 0;
  logic [9:0] pend_id = 10'd1023, eoi_id = 10'd0;
  logic [7:0] pend_prio = 8'hFF;

  logic [9:0] o_ack_id [2];
  logic       o_taken  [2];
  logic       o_done   [2];
  logic [9:0] o_run_id [2];
  logic [8:0] o_run_rp [2];

  sec_ack_unit u_sec_ack_unit (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .pend_id(pend_id),
    .pend_prio(pend_prio), .pend_grp(pend_grp), .req_secure(req_secure),
    .ack_ctl(ack_ctl), .eoi_req(eoi_req), .eoi_id(eoi_id), .eoi_grp(eoi_grp),
    .ack_id(o_ack_id[0]), .ack_taken(o_taken[0]), .eoi_done(o_done[0]),
    .run_id(o_run_id[0]), .run_prio(o_run_rp[0]));

  sec_ack_unit #(.HAS_SEC(1'b0)) u_sec_ack_unit_nosec (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .pend_id(pend_id),
    .pend_prio(pend_prio), .pend_grp(pend_grp), .req_secure(req_secure),
    .ack_ctl(ack_ctl), .eoi_req(eoi_req), .eoi_id(eoi_id), .eoi_grp(eoi_grp),
    .ack_id(o_ack_id[1]), .ack_taken(o_taken[1]), .eoi_done(o_done[1]),
    .run_id(o_run_id[1]), .run_prio(o_run_rp[1]));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Behavioural model, one per instance: running pair plus saved list.
  int m_id [2], m_rp [2], m_n [2];
  int m_sid [2][4], m_srp [2][4];
  int e_id [2];
  bit e_take [2], e_pop [2];

  task automatic chk(string tag, string what, int k, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s inst%0d: actual %0d expected %0d", tag, what, k, act, exp);
    end
  endtask

  task automatic predict(int k);
    bit sec = (k == 1) || req_secure;
    int e = int'(eoi_id);
    e_take[k] = 0;
    if (int'(pend_id) >= 1020)                e_id[k] = int'(pend_id);
    else if (!sec && !pend_grp)               e_id[k] = 1023;
    else if (sec && pend_grp && !ack_ctl)     e_id[k] = 1022;
    else if (int'(pend_prio) >= m_rp[k])      e_id[k] = 1023;
    else if (m_n[k] == 4)                     e_id[k] = 1023;
    else begin e_id[k] = int'(pend_id); e_take[k] = ack_req; end
    if (!ack_req) e_id[k] = 1023;
    e_pop[k] = eoi_req && !ack_req && !(!sec && !eoi_grp) && e < 1020 && e == m_id[k];
  endtask

  task automatic commit(int k);
    if (e_take[k]) begin
      if (m_id[k] != 1023) begin
        m_sid[k][m_n[k]] = m_id[k];
        m_srp[k][m_n[k]] = m_rp[k];
        m_n[k]++;
      end
      m_id[k] = int'(pend_id);
      m_rp[k] = int'(pend_prio);
    end else if (e_pop[k]) begin
      if (m_n[k] > 0) begin
        m_n[k]--;
        m_id[k] = m_sid[k][m_n[k]];
        m_rp[k] = m_srp[k][m_n[k]];
      end else begin
        m_id[k] = 1023;
        m_rp[k] = 256;
      end
    end
  endtask

  task automatic step(string tag);
    #2;
    for (int k = 0; k < 2; k++) begin
      predict(k);
      chk(tag, "ack_id", k, int'(o_ack_id[k]), e_id[k]);
      chk(tag, "ack_taken", k, int'(o_taken[k]), int'(e_take[k]));
      chk(tag, "eoi_done", k, int'(o_done[k]), int'(e_pop[k]));
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) commit(k);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(tag, "run_id", k, int'(o_run_id[k]), m_id[k]);
      chk(tag, "run_prio", k, int'(o_run_rp[k]), m_rp[k]);
    end
    ack_req = 0;
    eoi_req = 0;
  endtask

  task automatic do_ack(string tag, int id, int prio, bit grp, bit sec, bit ctl);
    ack_req = 1; pend_id = 10'(id); pend_prio = 8'(prio);
    pend_grp = grp; req_secure = sec; ack_ctl = ctl;
    step(tag);
  endtask

  task automatic do_eoi(string tag, int id, bit grp, bit sec, bit ctl);
    eoi_req = 1; eoi_id = 10'(id); eoi_grp = grp; req_secure = sec; ack_ctl = ctl;
    step(tag);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    wrap_up();
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_id[k] = 1023; m_rp[k] = 256; m_n[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 2; k++) begin
      chk("R1", "run_id", k, int'(o_run_id[k]), 1023);
      chk("R1", "run_prio", k, int'(o_run_rp[k]), 256);
      chk("R1", "ack_taken", k, int'(o_taken[k]), 0);
    end
    do_ack("R2", 1023, 8'h10, 1, 1, 1);      // nothing pending
    do_ack("R2", 1020, 8'h10, 0, 1, 1);      // first reserved ID passes through
    do_ack("R3", 40, 8'h80, 0, 0, 0);        // R13: no-security instance grants it
    do_eoi("R13", 40, 0, 0, 0);              // ns completion of group 0, only no-security instance pops
    do_ack("R4", 41, 8'hA0, 1, 1, 0);        // hidden: 1022
    do_ack("R4", 41, 8'hA0, 1, 1, 1);        // R7 grant
    do_ack("R6", 42, 8'hA0, 1, 0, 0);        // equal priority refused
    do_ack("R5", 42, 8'h90, 1, 0, 0);        // ns grant of group 1
    do_eoi("R9", 41, 1, 0, 0);               // not the running ID
    do_eoi("R8", 42, 1, 0, 0);               // pops back to 41
    do_ack("R7", 5, 8'h10, 0, 1, 1);
    do_eoi("R10", 5, 0, 0, 0);               // ns completion of group 0 dropped
    do_eoi("R8", 5, 0, 1, 1);
    do_eoi("R10", 41, 1, 1, 0);              // secure completion of group 1 with ack_ctl clear
    do_eoi("R9", 1023, 1, 1, 1);             // reserved ID never completes
    do_eoi("R9", 1020, 1, 1, 1);
    for (int i = 0; i < 5; i++) do_ack("R7", 100 + i, 8'h70 - 16 * i, 0, 1, 1);
    do_ack("R11", 105, 8'h20, 0, 1, 1);      // stack full: refused
    do_eoi("R8", 104, 0, 1, 1);
    ack_req = 1; pend_id = 10'd107; pend_prio = 8'h08; pend_grp = 0;
    eoi_req = 1; eoi_id = 10'd103; eoi_grp = 0; req_secure = 1; ack_ctl = 1;
    step("R12");
    do_eoi("R8", 107, 0, 1, 1);
    for (int i = 3; i >= 0; i--) do_eoi("R8", 100 + i, 0, 1, 1);
    do_ack("R2", 1019, 8'h00, 0, 1, 1);      // last valid ID granted
    do_eoi("R8", 1019, 0, 1, 1);
    do_ack("R6", 7, 8'hFF, 1, 0, 0);         // lowest urgency still beats idle
    do_ack("R6", 8, 8'hFF, 1, 0, 0);         // equal to running: refused
    do_eoi("R8", 7, 1, 0, 0);
    wrap_up();
  end

endmodule